// File: doc/BRIEF.md
# Control-endpoint SETUP receive-queue writer

This block sits between the packet decoder of a USB device controller and the shared 32-bit receive FIFO of its control OUT endpoints. For every SETUP packet the decoder hands over (eight payload bytes and the endpoint number), it pushes a three-word tagged entry into the FIFO: a control word first, then the payload packed little-endian across two data words. There is no flow control. SETUP traffic must never be refused, so the writer neither looks at FIFO occupancy nor at the endpoint's NAK or STALL state.

Alongside the data path it pulses NAK-set requests for both directions of the endpoint that took the SETUP, and it keeps a software-loadable SETUP counter that counts down and stops at zero. It also raises a sticky flag when more SETUP packets arrive in a row than the counter was meant to cover. When the control transfer moves out of its Setup stage, a one-word stage-done marker is queued. If that move is reported while a SETUP entry is still being written, the marker is held back until the entry is complete, so entries never interleave.

Top module: `setup_rxq_writer`

## Requirements
- R1: No input can stall the writer: SETUP strobes four cycles apart are all accepted, and each packet's three words appear on `fifo_wr` in three consecutive cycles, starting the cycle after the accepted strobe, whatever the counter value.
- R2: In the cycle after a SETUP strobe is accepted, `nak_in_set` and `nak_out_set` are both high for one cycle and `nak_ep` carries that packet's endpoint.
- R3: The first word of a SETUP entry is a control word: bits [3:0] endpoint, bits [14:4] byte count = 8, bits [16:15] zero, bits [20:17] status = 4'h6, bits [31:21] zero.
- R4: The second word holds payload bytes 0 to 3 and the third word holds bytes 4 to 7, little-endian: byte 0 is `setup_bytes[7:0]` and lands in bits [7:0] of the second word.
- R5: After reset the counter reads 0, the flag is clear and nothing is written. Each accepted SETUP strobe lowers the counter by one, visible the cycle after.
- R6: An accepted SETUP with the counter at 0 leaves it at 0. The packet is still written in full.
- R7: A pulse on `cnt_load` sets the counter to `cnt_load_val` on the next cycle and clears the back-to-back flag. A load takes priority over a decrement in the same cycle.
- R8: A `stage_vld` pulse while idle writes one word in the next cycle: endpoint from `stage_ep` in bits [3:0], byte count 0, status 4'h4 in bits [20:17], all other bits zero.
- R9: A `stage_vld` pulse that arrives in the same cycle as an accepted SETUP strobe, or while its three words are being written, produces its stage-done word in the cycle right after the third SETUP word.
- R10: `b2b_flag` rises the cycle after the fourth accepted SETUP since the last `stage_vld` pulse (or since reset). It stays high through later stage pulses until a counter load.
- R11: A SETUP strobe that arrives while a SETUP entry is being written is dropped. It writes no words, sends no NAK pulse and does not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_vld | input | 1 | One-cycle strobe: a SETUP packet has been received |
| setup_ep | input | 4 | Endpoint number of the SETUP packet |
| setup_bytes | input | 64 | SETUP payload, byte i at bits [8i+7:8i] |
| stage_vld | input | 1 | One-cycle strobe: the transfer leaves its Setup stage |
| stage_ep | input | 4 | Endpoint of the stage change |
| cnt_load | input | 1 | Load strobe for the SETUP counter |
| cnt_load_val | input | CNT_W | Value to load |
| fifo_wr | output | 1 | Receive FIFO write enable |
| fifo_wdata | output | 32 | Receive FIFO write data |
| nak_in_set | output | 1 | Pulse: set IN NAK of `nak_ep` |
| nak_out_set | output | 1 | Pulse: set OUT NAK of `nak_ep` |
| nak_ep | output | 4 | Endpoint the NAK pulses apply to |
| setup_cnt | output | CNT_W | SETUP packets still expected |
| b2b_flag | output | 1 | Sticky: more SETUPs in a row than the limit |

## Verification
The bench uses the default configuration: a 2-bit counter and a run limit of 3. At that size every load value from 0 to 3 can be crossed with every run length from 0 to 5 SETUPs. That covers normal countdown, the floor at zero, and the run lengths on both sides of the back-to-back threshold. All sixteen endpoint numbers are swept through the framing and NAK paths. A stage change is injected at each of the four cycles of an entry's write window, and a second SETUP strobe is injected inside that window.

// File: rtl/setup_rxq_pkg.sv
// Shared constants, state type and word builder for the SETUP receive-queue
// writer. Assumes a 32-bit receive FIFO word and 4-bit endpoint numbers.
package setup_rxq_pkg;

    localparam int EP_W       = 4;
    localparam int BCNT_W     = 11;
    localparam int WORD_W     = 32;
    localparam int SETUP_LEN  = 8;

    localparam logic [3:0] STS_SETUP_DATA = 4'h6;
    localparam logic [3:0] STS_STAGE_DONE = 4'h4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CTRL,
        SQ_LO,
        SQ_HI,
        SQ_DONE
    } sq_state_t;

    // Builds a control word: ep [3:0], byte count [14:4], status [20:17].
    function automatic logic [WORD_W-1:0] ctrl_word(
        input logic [3:0]        sts,
        input logic [EP_W-1:0]   ep,
        input logic [BCNT_W-1:0] bcnt
    );
        return {11'd0, sts, 2'b00, bcnt, ep};
    endfunction

endpackage

// File: rtl/setup_rxq_seq.sv
// Entry sequencer: captures an accepted SETUP packet, emits control word,
// low payload word and high payload word on consecutive cycles, and then any
// deferred stage-done word. Assumes the FIFO always takes a write.
// SETUP strobes are only accepted in the idle or stage-done cycles.
module setup_rxq_seq
    import setup_rxq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 setup_vld,
    input  logic [EP_W-1:0]      setup_ep,
    input  logic [63:0]          setup_bytes,
    input  logic                 stage_vld,
    input  logic [EP_W-1:0]      stage_ep,
    output logic                 setup_acc,
    output logic                 fifo_wr,
    output logic [WORD_W-1:0]    fifo_wdata,
    output logic                 nak_pulse,
    output logic [EP_W-1:0]      nak_ep
);

    sq_state_t           state_q, state_d;
    logic [EP_W-1:0]     pkt_ep_q;
    logic [63:0]         pkt_bytes_q;
    logic [EP_W-1:0]     stg_ep_q;
    logic                stg_pend_q;
    logic                stg_pend_d;
    logic                can_take;

    // Acceptance window: only between entries.
    assign can_take  = (state_q == SQ_IDLE) || (state_q == SQ_DONE);
    assign setup_acc = setup_vld && can_take;

    // Next-state and pending-marker decision.
    always_comb begin
        state_d    = state_q;
        stg_pend_d = stg_pend_q;
        unique case (state_q)
            SQ_IDLE, SQ_DONE: begin
                if (setup_vld) begin
                    state_d    = SQ_CTRL;
                    stg_pend_d = stage_vld;
                end else if (stage_vld) begin
                    state_d    = SQ_DONE;
                end else begin
                    state_d    = SQ_IDLE;
                end
            end
            SQ_CTRL: begin
                state_d    = SQ_LO;
                stg_pend_d = stg_pend_q || stage_vld;
            end
            SQ_LO: begin
                state_d    = SQ_HI;
                stg_pend_d = stg_pend_q || stage_vld;
            end
            SQ_HI: begin
                state_d    = (stg_pend_q || stage_vld) ? SQ_DONE : SQ_IDLE;
                stg_pend_d = 1'b0;
            end
            default: begin
                state_d    = SQ_IDLE;
                stg_pend_d = 1'b0;
            end
        endcase
    end

    // State, pending flag and NAK pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SQ_IDLE;
            stg_pend_q <= 1'b0;
            nak_pulse  <= 1'b0;
        end else begin
            state_q    <= state_d;
            stg_pend_q <= stg_pend_d;
            nak_pulse  <= setup_acc;
        end
    end

    // Packet and stage-endpoint capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_ep_q    <= '0;
            pkt_bytes_q <= '0;
            stg_ep_q    <= '0;
        end else begin
            if (setup_acc) begin
                pkt_ep_q    <= setup_ep;
                pkt_bytes_q <= setup_bytes;
            end
            if (stage_vld) begin
                stg_ep_q <= stage_ep;
            end
        end
    end

    assign nak_ep  = pkt_ep_q;
    assign fifo_wr = (state_q != SQ_IDLE);

    // Word selection for the current write cycle.
    always_comb begin
        unique case (state_q)
            SQ_CTRL: fifo_wdata = ctrl_word(STS_SETUP_DATA, pkt_ep_q,
                                            BCNT_W'(SETUP_LEN));
            SQ_LO:   fifo_wdata = pkt_bytes_q[31:0];
            SQ_HI:   fifo_wdata = pkt_bytes_q[63:32];
            SQ_DONE: fifo_wdata = ctrl_word(STS_STAGE_DONE, stg_ep_q, '0);
            default: fifo_wdata = '0;
        endcase
    end

endmodule

// File: rtl/setup_rxq_count.sv
// SETUP counter and run tracker: a loadable down-counter that stops at zero
// and a saturating run length of SETUPs since the last stage change. A sticky
// flag is set once the run exceeds RUN_LIMIT. Assumes one-cycle strobes.
module setup_rxq_count #(
    parameter int CNT_W     = 2,
    parameter int RUN_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_acc,
    input  logic             stage_vld,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_load_val,
    output logic [CNT_W-1:0] setup_cnt,
    output logic             b2b_flag
);

    localparam int RUN_W = $clog2(RUN_LIMIT + 2);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LIMIT + 1);
    localparam logic [RUN_W-1:0] RUN_TRIP = RUN_W'(RUN_LIMIT);

    logic [RUN_W-1:0] run_q;

    // Down-counter with load priority and a floor at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_cnt <= '0;
        end else if (cnt_load) begin
            setup_cnt <= cnt_load_val;
        end else if (setup_acc && (setup_cnt != '0)) begin
            setup_cnt <= setup_cnt - 1'b1;
        end
    end

    // Run length of SETUPs since the last stage change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (stage_vld) begin
            run_q <= '0;
        end else if (setup_acc && (run_q != RUN_MAX)) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Sticky over-run flag, cleared by a counter load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b2b_flag <= 1'b0;
        end else if (cnt_load) begin
            b2b_flag <= 1'b0;
        end else if (setup_acc && (run_q >= RUN_TRIP)) begin
            b2b_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/setup_rxq_writer.sv
// Top of the SETUP receive-queue writer: joins the entry sequencer and the
// counter/run tracker. Assumes the FIFO behind fifo_wr always has room.
module setup_rxq_writer
    import setup_rxq_pkg::*;
#(
    parameter int CNT_W     = 2,
    parameter int RUN_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_vld,
    input  logic [3:0]       setup_ep,
    input  logic [63:0]      setup_bytes,
    input  logic             stage_vld,
    input  logic [3:0]       stage_ep,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_load_val,
    output logic             fifo_wr,
    output logic [31:0]      fifo_wdata,
    output logic             nak_in_set,
    output logic             nak_out_set,
    output logic [3:0]       nak_ep,
    output logic [CNT_W-1:0] setup_cnt,
    output logic             b2b_flag
);

    logic setup_acc;
    logic nak_pulse;

    setup_rxq_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_vld   (setup_vld),
        .setup_ep    (setup_ep),
        .setup_bytes (setup_bytes),
        .stage_vld   (stage_vld),
        .stage_ep    (stage_ep),
        .setup_acc   (setup_acc),
        .fifo_wr     (fifo_wr),
        .fifo_wdata  (fifo_wdata),
        .nak_pulse   (nak_pulse),
        .nak_ep      (nak_ep)
    );

    setup_rxq_count #(
        .CNT_W     (CNT_W),
        .RUN_LIMIT (RUN_LIMIT)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .setup_acc    (setup_acc),
        .stage_vld    (stage_vld),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val),
        .setup_cnt    (setup_cnt),
        .b2b_flag     (b2b_flag)
    );

    // Both NAK directions are set together for a SETUP.
    assign nak_in_set  = nak_pulse;
    assign nak_out_set = nak_pulse;

endmodule

// File: rtl/setup_rxq_checker.sv
// Property checker for setup_rxq_writer, bound to every instance.
module setup_rxq_checker #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             setup_acc,
    input logic             cnt_load,
    input logic [CNT_W-1:0] cnt_load_val,
    input logic             fifo_wr,
    input logic [31:0]      fifo_wdata,
    input logic             nak_in_set,
    input logic             nak_out_set,
    input logic [CNT_W-1:0] setup_cnt,
    input logic             b2b_flag
);

    a_r1_three_writes: assert property (@(posedge clk) disable iff (!rst_n)
        setup_acc |=> fifo_wr ##1 fifo_wr ##1 fifo_wr);

    a_r2_nak_both: assert property (@(posedge clk) disable iff (!rst_n)
        setup_acc |=> (nak_in_set && nak_out_set));

    a_r3_ctrl_first: assert property (@(posedge clk) disable iff (!rst_n)
        setup_acc |=> (fifo_wdata[20:17] == 4'h6 && fifo_wdata[14:4] == 11'd8));

    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_acc && !cnt_load && setup_cnt != '0)
            |=> (setup_cnt == $past(setup_cnt) - 1'b1));

    a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_acc && !cnt_load && setup_cnt == '0) |=> (setup_cnt == '0));

    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> (setup_cnt == $past(cnt_load_val) && !b2b_flag));

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (b2b_flag && !cnt_load) |=> b2b_flag);

endmodule

bind setup_rxq_writer setup_rxq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .setup_acc    (setup_acc),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .fifo_wr      (fifo_wr),
    .fifo_wdata   (fifo_wdata),
    .nak_in_set   (nak_in_set),
    .nak_out_set  (nak_out_set),
    .setup_cnt    (setup_cnt),
    .b2b_flag     (b2b_flag)
);

// File: tb/setup_rxq_writer_bench.sv
module setup_rxq_writer_bench;

    localparam int CLK_P = 10;
    localparam int CW    = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          setup_vld;
    logic [3:0]    setup_ep;
    logic [63:0]   setup_bytes;
    logic          stage_vld;
    logic [3:0]    stage_ep;
    logic          cnt_load;
    logic [CW-1:0] cnt_load_val;
    logic          fifo_wr;
    logic [31:0]   fifo_wdata;
    logic          nak_in_set;
    logic          nak_out_set;
    logic [3:0]    nak_ep;
    logic [CW-1:0] setup_cnt;
    logic          b2b_flag;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int lc    = 0;
    logic [31:0] lw [0:1023];
    int          lt [0:1023];

    always #(CLK_P/2) clk = ~clk;

    setup_rxq_writer #(.CNT_W(CW), .RUN_LIMIT(3)) u_setup_rxq_writer (
        .clk(clk), .rst_n(rst_n), .setup_vld(setup_vld), .setup_ep(setup_ep),
        .setup_bytes(setup_bytes), .stage_vld(stage_vld), .stage_ep(stage_ep),
        .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .fifo_wr(fifo_wr),
        .fifo_wdata(fifo_wdata), .nak_in_set(nak_in_set),
        .nak_out_set(nak_out_set), .nak_ep(nak_ep), .setup_cnt(setup_cnt),
        .b2b_flag(b2b_flag)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // FIFO write logger, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && fifo_wr && lc < 1024) begin
            lw[lc] = fifo_wdata;
            lt[lc] = cyc;
            lc     = lc + 1;
        end
    end

    function automatic logic [31:0] mk_ctrl(logic [3:0] sts, logic [3:0] ep, int bc);
        logic [31:0] w;
        w        = 32'd0;
        w[3:0]   = ep;
        w[14:4]  = bc[10:0];
        w[20:17] = sts;
        return w;
    endfunction

    function automatic logic [63:0] mk_bytes(int seed);
        logic [63:0] b;
        for (int i = 0; i < 8; i++) b[8*i +: 8] = 8'((seed * 37 + i * 19 + 3) & 255);
        return b;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge where the writer is free again.
    task automatic send_setup(logic [3:0] ep, logic [63:0] b);
        setup_vld = 1'b1; setup_ep = ep; setup_bytes = b;
        @(negedge clk);
        setup_vld = 1'b0;
        #1;
        chk("R2 nak_in", {31'd0, nak_in_set}, 32'd1);
        chk("R2 nak_out", {31'd0, nak_out_set}, 32'd1);
        chk("R2 nak_ep", {28'd0, nak_ep}, {28'd0, ep});
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_stage(logic [3:0] ep);
        stage_vld = 1'b1; stage_ep = ep;
        @(negedge clk);
        stage_vld = 1'b0;
    endtask

    task automatic do_load(logic [CW-1:0] v);
        cnt_load = 1'b1; cnt_load_val = v;
        @(negedge clk);
        cnt_load = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic chk_entry(int base, logic [3:0] ep, logic [63:0] b);
        chk("R3 ctrl word", lw[base], mk_ctrl(4'h6, ep, 8));
        chk("R4 low word", lw[base+1], b[31:0]);
        chk("R4 high word", lw[base+2], b[63:32]);
        chk("R1 consecutive", 32'(lt[base+2] - lt[base]), 32'd2);
    endtask

    initial begin
        #(CLK_P * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        int exp_cnt;
        rst_n = 1'b0; setup_vld = 1'b0; setup_ep = '0; setup_bytes = '0;
        stage_vld = 1'b0; stage_ep = '0; cnt_load = 1'b0; cnt_load_val = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R5 reset cnt", 32'(setup_cnt), 32'd0);
        chk("R5 reset flag", {31'd0, b2b_flag}, 32'd0);
        chk("R5 reset wr", {31'd0, fifo_wr}, 32'd0);
        @(negedge clk);

        // R1/R3/R4: all endpoints back to back at minimum spacing, counter at 0 (R6).
        pulse_stage(4'd0);
        settle();
        @(negedge clk);
        base = lc;
        for (int e = 0; e < 16; e++) send_setup(4'(e), mk_bytes(e));
        settle();
        chk("R1 word count", 32'(lc - base), 32'd48);
        for (int e = 0; e < 16; e++) begin
            chk_entry(base + 3 * e, 4'(e), mk_bytes(e));
            chk("R1 spacing", 32'(lt[base + 3 * e] - lt[base]), 32'(4 * e));
        end
        chk("R6 floor after 16", 32'(setup_cnt), 32'd0);
        chk("R10 flag after 16", {31'd0, b2b_flag}, 32'd1);
        @(negedge clk);

        // R10: stage pulse does not clear the flag; load does.
        pulse_stage(4'd2);
        settle();
        chk("R10 sticky", {31'd0, b2b_flag}, 32'd1);
        chk("R8 stage word", lw[lc-1], mk_ctrl(4'h4, 4'd2, 0));
        @(negedge clk);
        do_load(2'd1);
        #1;
        chk("R7 load value", 32'(setup_cnt), 32'd1);
        chk("R7 flag cleared", {31'd0, b2b_flag}, 32'd0);
        @(negedge clk);

        // R5/R6/R7/R10 sweep: every load value against run lengths 0..5.
        for (int ld = 0; ld < 4; ld++) begin
            for (int n = 0; n < 6; n++) begin
                pulse_stage(4'd1);
                do_load(CW'(ld));
                for (int k = 0; k < n; k++) send_setup(4'(k), mk_bytes(ld * 8 + k));
                settle();
                exp_cnt = (ld > n) ? ld - n : 0;
                chk($sformatf("R5 R6 cnt ld=%0d n=%0d", ld, n), 32'(setup_cnt), 32'(exp_cnt));
                chk($sformatf("R10 flag ld=%0d n=%0d", ld, n), {31'd0, b2b_flag}, (n > 3) ? 32'd1 : 32'd0);
                @(negedge clk);
            end
        end

        // R8: stage word while idle, every endpoint.
        for (int e = 0; e < 16; e++) begin
            base = lc;
            pulse_stage(4'(e));
            settle();
            chk("R8 one word", 32'(lc - base), 32'd1);
            chk("R8 stage word", lw[base], mk_ctrl(4'h4, 4'(e), 0));
            @(negedge clk);
        end

        // R9: stage change at each cycle of the entry window.
        for (int off = 0; off < 4; off++) begin
            base = lc;
            setup_vld = 1'b1; setup_ep = 4'(off + 3); setup_bytes = mk_bytes(90 + off);
            stage_vld = (off == 0); stage_ep = 4'(12 - off);
            @(negedge clk);
            setup_vld = 1'b0; stage_vld = 1'b0;
            for (int k = 1; k < 4; k++) begin
                stage_vld = (k == off);
                @(negedge clk);
                stage_vld = 1'b0;
            end
            settle();
            chk($sformatf("R9 count off=%0d", off), 32'(lc - base), 32'd4);
            chk_entry(base, 4'(off + 3), mk_bytes(90 + off));
            chk($sformatf("R9 marker off=%0d", off), lw[base+3], mk_ctrl(4'h4, 4'(12 - off), 0));
            chk("R9 marker adjacent", 32'(lt[base+3] - lt[base+2]), 32'd1);
            @(negedge clk);
        end

        // R11: a second SETUP strobe inside the write window is dropped.
        for (int k = 1; k < 4; k++) begin
            do_load(2'd3);
            base = lc;
            setup_vld = 1'b1; setup_ep = 4'd5; setup_bytes = mk_bytes(200);
            @(negedge clk);
            setup_vld = 1'b0;
            for (int j = 1; j < 4; j++) begin
                if (j == k) begin
                    setup_vld = 1'b1; setup_ep = 4'd9; setup_bytes = mk_bytes(201);
                end
                @(negedge clk);
                setup_vld = 1'b0;
                #1;
                if (j == k + 1) chk("R11 no nak", {31'd0, nak_in_set}, 32'd0);
            end
            settle();
            chk($sformatf("R11 words k=%0d", k), 32'(lc - base), 32'd3);
            chk_entry(base, 4'd5, mk_bytes(200));
            chk("R11 cnt", 32'(setup_cnt), 32'd2);
            @(negedge clk);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule